// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Trigger with Wait-Hold

This block sits on a microcomputer backplane and stops the processor inside one chosen bus cycle. At the rising edge of the cycle-start strobe it reads the status lines and puts the cycle into one of six classes: memory read, opcode fetch, memory write, I/O in, I/O out or interrupt acknowledge. It then compares the bus address against a programmed breakpoint address. If the class and address match the programmed trigger, it pulls the ready line low on the next clock. This inserts wait states before the processor commits the cycle.

The write status line on such a bus is only a delayed write strobe. It appears after the cycle-start strobe has ended, which is too late to stall the cycle. For that reason a memory write is inferred when no other status line is active during the cycle-start strobe. Optionally the trigger can also require the data byte to equal a programmed pattern. In that case the stall is held until the data bus is marked valid. A mismatch then releases the cycle, and a match turns the stall into a full halt. A halt lasts until a one-clock resume pulse.

A small write-only configuration port loads the breakpoint address, the data pattern and the control bits. A sticky hit flag reports that a halt has happened.

Top module: `bus_break_trigger`

## Requirements
- R1: While reset is low and right after it, readyOut is 1, hitFlag is 0 and the trigger is disabled.
- R2: The cycle class is taken at the rising edge of syncStrobe. Interrupt acknowledge wins over opcode fetch, which wins over memory read, then I/O in, then I/O out. The class codes are 0 memory read, 1 opcode fetch, 2 memory write, 3 I/O in, 4 I/O out and 5 interrupt acknowledge.
- R3: A cycle with none of the five status lines active at the syncStrobe rising edge is a memory write (class 2).
- R4: In narrow mode only address bits 15:0 are compared. In wide mode all 24 bits are compared.
- R5: When the class, the address and the enable all match at a syncStrobe rising edge, readyOut is 0 from the next clock on.
- R6: With data matching off, a match sets hitFlag at the same clock as readyOut falls. readyOut then stays 0 for as long as resume is absent. hitFlag stays 1 until a configuration write.
- R7: With data matching on, readyOut stays 0 until dataStrobe. Then busData equal to the pattern sets hitFlag and keeps the halt. Unequal data releases readyOut on the next clock and leaves hitFlag at 0.
- R8: A resume pulse while halted sets readyOut to 1 on the next clock. No new trigger happens until a fresh syncStrobe rising edge, even if syncStrobe stays high.
- R9: With the enable bit at 0, no bus cycle lowers readyOut.
- R10: Any configuration write clears hitFlag. The register select codes are 0 for the address (cfgWdata 23:0) and 1 for the pattern (cfgWdata 7:0). Code 2 is the control register, with cfgWdata 2:0 as the class, bit 3 as wide mode, bit 4 as data-match enable and bit 5 as enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgWdata | input | 24 | Configuration write data |
| syncStrobe | input | 1 | Bus cycle-start strobe |
| statMemRd | input | 1 | Memory read status |
| statFetch | input | 1 | Opcode fetch status |
| statIn | input | 1 | I/O input status |
| statOut | input | 1 | I/O output status |
| statIntAck | input | 1 | Interrupt acknowledge status |
| busAddr | input | 24 | Bus address |
| busData | input | 8 | Bus data byte |
| dataStrobe | input | 1 | Data bus valid marker |
| resume | input | 1 | One-clock release of a halt |
| readyOut | output | 1 | Bus ready, 0 inserts wait states |
| hitFlag | output | 1 | Sticky breakpoint-hit flag |

## Verification
A wrong class latch or a wrong address comparison shows one clock after the syncStrobe rising edge. readyOut then either falls when it must not or stays high when it must fall, and both sides of each decision are driven. A stuck control state shows as readyOut failing to return one clock after resume or a data mismatch, or falling again while syncStrobe is still held high. A lost or spurious hit shows on hitFlag at the clock where the halt starts and after each configuration write.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [2:0] {
    KIND_MEMRD = 3'd0,
    KIND_FETCH = 3'd1,
    KIND_WRITE = 3'd2,
    KIND_IOIN  = 3'd3,
    KIND_IOOUT = 3'd4,
    KIND_INTA  = 3'd5
  } cycleKind_t;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_PAT  = 2'd1,
    SEL_CTRL = 2'd2
  } cfgSel_t;

  // datapath -> control
  typedef struct packed {
    logic syncRise;
    logic cycleMatch;
    logic dataEnable;
    logic dataMatch;
  } dpStatus_t;

  // control -> datapath
  typedef struct packed {
    logic setHit;
  } ctlStrobe_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              syncStrobe,
  input  logic              statMemRd,
  input  logic              statFetch,
  input  logic              statIn,
  input  logic              statOut,
  input  logic              statIntAck,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         st,
  output logic              hitFlag,
  output logic              cfgEnable
);
  localparam int CTRL_W = 6;

  logic [ADDR_W-1:0] bpAddr;
  logic [DATA_W-1:0] bpPattern;
  cycleKind_t        bpKind;
  logic              bpWide;
  logic              bpDataEn;
  logic              syncPrev;
  cycleKind_t        curKind;
  logic              addrHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpAddr    <= '0;
      bpPattern <= '0;
      bpKind    <= KIND_MEMRD;
      bpWide    <= 1'b0;
      bpDataEn  <= 1'b0;
      cfgEnable <= 1'b0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_ADDR: bpAddr    <= cfgWdata;
        SEL_PAT:  bpPattern <= cfgWdata[DATA_W-1:0];
        SEL_CTRL: begin
          bpKind    <= cycleKind_t'(cfgWdata[2:0]);
          bpWide    <= cfgWdata[3];
          bpDataEn  <= cfgWdata[4];
          cfgEnable <= cfgWdata[CTRL_W-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      hitFlag  <= 1'b0;
    end else begin
      syncPrev <= syncStrobe;
      if (ctl.setHit)  hitFlag <= 1'b1;
      else if (cfgWe)  hitFlag <= 1'b0;
    end
  end

  // Write is inferred from silence on every other status line.
  always_comb begin
    if (statIntAck)     curKind = KIND_INTA;
    else if (statFetch) curKind = KIND_FETCH;
    else if (statMemRd) curKind = KIND_MEMRD;
    else if (statIn)    curKind = KIND_IOIN;
    else if (statOut)   curKind = KIND_IOOUT;
    else                curKind = KIND_WRITE;
  end

  always_comb begin
    addrHit = (busAddr[NARROW_W-1:0] == bpAddr[NARROW_W-1:0]);
    if (bpWide)
      addrHit = addrHit && (busAddr[ADDR_W-1:NARROW_W] == bpAddr[ADDR_W-1:NARROW_W]);
  end

  assign st.syncRise   = syncStrobe && !syncPrev;
  assign st.cycleMatch = cfgEnable && (curKind == bpKind) && addrHit;
  assign st.dataEnable = bpDataEn;
  assign st.dataMatch  = (busData == bpPattern);
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  st,
  input  logic       dataStrobe,
  input  logic       resume,
  output ctlStrobe_t ctl,
  output logic       readyOut
);
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DWAIT = 2'd1,
    ST_HALT  = 2'd2
  } ctlState_t;

  ctlState_t state, stateNext;

  always_comb begin
    stateNext  = state;
    ctl.setHit = 1'b0;
    case (state)
      ST_IDLE:
        if (st.syncRise && st.cycleMatch) begin
          if (st.dataEnable) stateNext = ST_DWAIT;
          else begin
            stateNext  = ST_HALT;
            ctl.setHit = 1'b1;
          end
        end
      ST_DWAIT:
        if (dataStrobe) begin
          if (st.dataMatch) begin
            stateNext  = ST_HALT;
            ctl.setHit = 1'b1;
          end else stateNext = ST_IDLE;
        end
      ST_HALT:
        if (resume) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign readyOut = (state == ST_IDLE);
endmodule

// File: rtl/bus_break_trigger.sv
module bus_break_trigger
  import brk_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              syncStrobe,
  input  logic              statMemRd,
  input  logic              statFetch,
  input  logic              statIn,
  input  logic              statOut,
  input  logic              statIntAck,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              dataStrobe,
  input  logic              resume,
  output logic              readyOut,
  output logic              hitFlag
);
  dpStatus_t  dpSt;
  ctlStrobe_t ctlStr;
  logic       cfgEnable;

  brk_datapath #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .syncStrobe(syncStrobe), .statMemRd(statMemRd), .statFetch(statFetch),
    .statIn(statIn), .statOut(statOut), .statIntAck(statIntAck),
    .busAddr(busAddr), .busData(busData), .ctl(ctlStr), .st(dpSt),
    .hitFlag(hitFlag), .cfgEnable(cfgEnable)
  );

  brk_control uCtl (
    .clk(clk), .rstN(rstN), .st(dpSt), .dataStrobe(dataStrobe),
    .resume(resume), .ctl(ctlStr), .readyOut(readyOut)
  );
endmodule

// File: rtl/brk_checker.sv
module brk_checker (
  input logic clk,
  input logic rstN,
  input logic syncStrobe,
  input logic resume,
  input logic dataStrobe,
  input logic cfgWe,
  input logic cfgEnable,
  input logic setHit,
  input logic readyOut,
  input logic hitFlag
);
  AST_STALL_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |-> $past(syncStrobe));                               // R5
  AST_HIT_WITH_STALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitFlag) |-> !readyOut);                                        // R6
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hitFlag && !cfgWe |=> hitFlag);                                       // R6
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> ($past(resume) || $past(dataStrobe)));            // R8
  AST_DISABLED_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable && readyOut |=> readyOut);                                 // R9
  AST_CFG_CLEARS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && !setHit |=> !hitFlag);                                       // R10
endmodule

bind bus_break_trigger brk_checker uChk (
  .clk(clk), .rstN(rstN), .syncStrobe(syncStrobe), .resume(resume),
  .dataStrobe(dataStrobe), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
  .setHit(ctlStr.setHit), .readyOut(readyOut), .hitFlag(hitFlag)
);

// File: tb/bus_break_trigger_test.sv
module bus_break_trigger_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [23:0] cfgWdata = '0;
  logic syncStrobe = 1'b0;
  logic statMemRd = 1'b0, statFetch = 1'b0, statIn = 1'b0, statOut = 1'b0, statIntAck = 1'b0;
  logic [23:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic dataStrobe = 1'b0;
  logic resume = 1'b0;
  logic readyOut, hitFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_break_trigger uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .syncStrobe(syncStrobe), .statMemRd(statMemRd), .statFetch(statFetch),
    .statIn(statIn), .statOut(statOut), .statIntAck(statIntAck),
    .busAddr(busAddr), .busData(busData), .dataStrobe(dataStrobe),
    .resume(resume), .readyOut(readyOut), .hitFlag(hitFlag)
  );

  localparam logic [23:0] BP_ADDR = 24'h123456;

  // {kind, wide, status {intAck,fetch,memRd,in,out}, bus address, expect stall}
  typedef struct packed {
    logic [2:0]  kind;
    logic        wide;
    logic [4:0]  stat;
    logic [23:0] addr;
    logic        stall;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 5'b00100, 24'h123456, 1'b1},  // R2 memory read
    '{3'd0, 1'b0, 5'b01100, 24'h123456, 1'b0},  // R2 fetch beats memrd
    '{3'd1, 1'b0, 5'b01100, 24'h123456, 1'b1},  // R2 fetch
    '{3'd2, 1'b0, 5'b00000, 24'h123456, 1'b1},  // R3 inferred write
    '{3'd2, 1'b0, 5'b00100, 24'h123456, 1'b0},  // R3 read is not write
    '{3'd3, 1'b0, 5'b00010, 24'h123456, 1'b1},  // R2 io in
    '{3'd4, 1'b0, 5'b00001, 24'h123456, 1'b1},  // R2 io out
    '{3'd5, 1'b0, 5'b11000, 24'h123456, 1'b1},  // R2 intack beats fetch
    '{3'd0, 1'b0, 5'b00100, 24'h993456, 1'b1},  // R4 narrow ignores top
    '{3'd0, 1'b1, 5'b00100, 24'h993456, 1'b0},  // R4 wide compares top
    '{3'd0, 1'b1, 5'b00100, 24'h123456, 1'b1},  // R4 wide equal
    '{3'd2, 1'b0, 5'b00000, 24'h123457, 1'b0}   // R4 low bit differs
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [23:0] data);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setStatus(input logic [4:0] s);
    {statIntAck, statFetch, statMemRd, statIn, statOut} = s;
  endtask

  // control word: bit5 enable, bit4 data match, bit3 wide, bits2:0 class
  function automatic logic [23:0] ctrlWord(input logic en, input logic dm, input logic wide, input logic [2:0] k);
    return {18'd0, en, dm, wide, k};
  endfunction

  task automatic syncPulse(input logic [4:0] s, input logic [23:0] a);
    setStatus(s); busAddr = a; syncStrobe = 1'b1;
    @(negedge clk);
    syncStrobe = 1'b0; setStatus(5'b0);
  endtask

  task automatic resumePulse();
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", readyOut, 1'b1, "ready in reset");
    check("R1", hitFlag, 1'b0, "hit in reset");
    rstN = 1'b1;
    @(negedge clk);
    syncPulse(5'b00000, 24'h000000);   // would be write to 0 if enabled
    check("R1", readyOut, 1'b1, "disabled after reset");

    cfgWrite(2'd0, BP_ADDR);
    for (int i = 0; i < NVEC; i++) begin
      cfgWrite(2'd2, ctrlWord(1'b1, 1'b0, VECS[i].wide, VECS[i].kind));
      syncPulse(VECS[i].stat, VECS[i].addr);
      check("R2/R3/R4/R5", readyOut, !VECS[i].stall, $sformatf("vector %0d ready", i));
      check("R6", hitFlag, VECS[i].stall, $sformatf("vector %0d hit", i));
      if (VECS[i].stall) begin
        resumePulse();
        check("R8", readyOut, 1'b1, $sformatf("vector %0d resume", i));
      end
    end

    // R6: long hold, hit sticky after resume, R10 clear on config write
    cfgWrite(2'd2, ctrlWord(1'b1, 1'b0, 1'b0, 3'd0));
    syncPulse(5'b00100, BP_ADDR);
    repeat (20) @(negedge clk);
    check("R6", readyOut, 1'b0, "held without resume");
    resumePulse();
    check("R6", hitFlag, 1'b1, "hit sticky after resume");
    cfgWrite(2'd1, 24'h0000A5);
    check("R10", hitFlag, 1'b0, "config write clears hit");

    // R7: data match
    cfgWrite(2'd2, ctrlWord(1'b1, 1'b1, 1'b0, 3'd2));
    syncPulse(5'b00000, BP_ADDR);
    check("R7", readyOut, 1'b0, "stall before data");
    check("R7", hitFlag, 1'b0, "no hit before data");
    repeat (3) @(negedge clk);
    dataStrobe = 1'b1; busData = 8'hA5;
    @(negedge clk);
    dataStrobe = 1'b0;
    check("R7", readyOut, 1'b0, "data match halts");
    check("R7", hitFlag, 1'b1, "data match hit");
    resumePulse();
    check("R8", readyOut, 1'b1, "resume after data halt");
    cfgWrite(2'd1, 24'h0000A5);
    syncPulse(5'b00000, BP_ADDR);
    dataStrobe = 1'b1; busData = 8'h3C;
    @(negedge clk);
    dataStrobe = 1'b0;
    check("R7", readyOut, 1'b1, "data mismatch releases");
    check("R7", hitFlag, 1'b0, "data mismatch no hit");

    // R8: no retrigger while sync held high
    cfgWrite(2'd2, ctrlWord(1'b1, 1'b0, 1'b0, 3'd0));
    setStatus(5'b00100); busAddr = BP_ADDR; syncStrobe = 1'b1;
    @(negedge clk);
    check("R5", readyOut, 1'b0, "stall with sync held");
    resumePulse();
    check("R8", readyOut, 1'b1, "release with sync held");
    @(negedge clk);
    check("R8", readyOut, 1'b1, "no retrigger same cycle");
    syncStrobe = 1'b0; setStatus(5'b0);
    @(negedge clk);

    // R9: disabled
    cfgWrite(2'd2, ctrlWord(1'b0, 1'b0, 1'b0, 3'd0));
    syncPulse(5'b00100, BP_ADDR);
    check("R9", readyOut, 1'b1, "disabled ignores match");
    @(negedge clk);
    check("R9", hitFlag, 1'b0, "disabled no hit");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule